// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Selectable Line Routing

This block is a full-duplex asynchronous serial transmitter and receiver. A 13-bit divisor sets the bit rate through a baud generator. The generator emits one oversampling tick every `baud_div` bus clocks, and one bit time is sixteen ticks. Setting the divisor to zero stops the ticks, and with them all transmit and receive activity. Characters are 8 or 9 data bits. Each frame has one low start bit, the data bits least significant first, and one high stop bit.

Two control inputs select how the pins are wired:

- **Normal two-pin mode:** the transmitter drives `txd_out` and the receiver listens on `rxd_in`.
- **Internal loopback:** the receiver listens to the transmitter's own output, and `rxd_in` is ignored.
- **Single-wire mode:** `txd_out` carries the transmitter and is enabled only while a frame is going out. The receiver hears that shared line: its own frames while driving, and the external level (`txd_pin_in`) while released.

The receiver oversamples by sixteen. It accepts a start bit only if the line is still low at mid-bit, and samples each later bit at its centre. A stop bit sampled low flags a framing error, and the word is still presented. After such an error the receiver waits for the line to go high before looking for a new start bit.

A word written while a frame is in progress waits in a one-word holding slot. If that slot is written again before the frame ends, the newest word replaces the older one. The held word is sent when the current stop bit has completed.

Top module: `uart_loop_core`

## Requirements
- R1: With `baud_div` = D (1..8191), every transmitted bit lasts exactly 16·D clock cycles.
- R2: With `baud_div` = 0, no ticks occur and `txd_out` stays high. A word written meanwhile is kept, and it is sent once a nonzero divisor is applied.
- R3: In 8-bit mode (`nine_bit`=0), a frame is a start bit at 0, then data bits 0..7 lsb first, then a stop bit at 1.
- R4: In 9-bit mode (`nine_bit`=1), data bit 8 is sent after bit 7 and before the stop bit, and the receiver returns all 9 bits.
- R5: With `loop_en`=0, a frame arriving on `rxd_in` is presented on `rx_data` with a one-cycle `rx_valid` pulse. In 8-bit mode, `rx_data[8]` is 0.
- R6: With `loop_en`=1 and `rx_src`=0, the receiver gets the transmitter's output internally, and `rxd_in` has no effect.
- R7: With `loop_en`=1 and `rx_src`=1, `txd_oe` is high only while a frame is being sent. The receiver gets the transmitted frame, and while `txd_oe` is low it gets `txd_pin_in`. `rxd_in` is ignored.
- R8: With `loop_en`=0, `rx_src` has no effect: `txd_oe` stays high, the receiver listens only to `rxd_in`, and transmitted frames are not received.
- R9: A stop bit sampled low sets `rx_frame_err` together with `rx_valid`, and the received word is still presented. `rx_frame_err` holds until the next word, which updates it.
- R10: After reset, and whenever no frame is being sent, `txd_out` is high. After reset, `rx_valid` is 0.
- R11: A word written during a frame is started after that frame's stop bit completes, within one tick of it, and not earlier.
- R12: A low pulse on the receive line shorter than half a bit time is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 13 | Baud divisor; 0 stops the generator |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| loop_en | input | 1 | 1 routes the transmitter to the receiver |
| rx_src | input | 1 | With loop_en, 1 selects single-wire mode |
| tx_data | input | 9 | Word to transmit |
| tx_wr | input | 1 | Write strobe for tx_data |
| rxd_in | input | 1 | Receive pin (normal mode) |
| txd_pin_in | input | 1 | Level sensed on the transmit pin |
| txd_out | output | 1 | Transmit pin drive value |
| txd_oe | output | 1 | Transmit pin output enable |
| rx_data | output | 9 | Last received word |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |
| rx_frame_err | output | 1 | Stop bit of the last word was low |

## Verification
A frame starts on the first tick after a write. That means `txd_out` falls within D+1 cycles of the strobe, and each bit centre then lies 16·D·k + 8·D cycles after the falling edge. The bench finds the falling edge at a falling clock edge and samples each bit at its centre, so every sample sits half a bit away from any transition. `rx_valid` arrives during the stop bit, about 9.5 or 10.5 bit times after the start edge plus a two-cycle synchronizer, and it is caught by a monitor that runs on falling clock edges. The bench reads that record only after the full frame and one idle bit have passed. Back-to-back frames are timed by counting cycles from the first stop-bit centre to the next falling edge, which must be between 8·D and 10·D cycles.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;
  localparam int WORD_W  = 9;
  localparam int FRAME_W = WORD_W + 2;

  typedef enum logic [1:0] {
    ROUTE_NORMAL = 2'd0,
    ROUTE_LOOP   = 2'd1,
    ROUTE_SINGLE = 2'd2
  } route_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;

  // Decode of the two routing controls; rx_src only matters with loop_en set.
  function automatic route_e pick_route(input logic loop_en, input logic rx_src);
    if (!loop_en) return ROUTE_NORMAL;
    return rx_src ? ROUTE_SINGLE : ROUTE_LOOP;
  endfunction

  // Number of bit slots in a frame, start and stop included.
  function automatic logic [3:0] frame_len(input logic nine);
    return nine ? 4'd11 : 4'd10;
  endfunction

  // Frame image shifted out from bit 0: start, data lsb first, stop.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [WORD_W-1:0] w,
                                                     input logic nine);
    return {1'b1, (nine ? w[8] : 1'b1), w[7:0], 1'b0};
  endfunction

  // Received shift register holds bits MSB-aligned; right-justify for 8-bit words.
  function automatic logic [WORD_W-1:0] align_word(input logic [WORD_W-1:0] sr,
                                                   input logic nine);
    return nine ? sr : {1'b0, sr[WORD_W-1:1]};
  endfunction
endpackage

// File: rtl/uart_lc_baud.sv
module uart_lc_baud #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (div != '0) && (cnt >= div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      cnt  <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_lc_tx.sv
module uart_lc_tx
  import uart_lc_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine_bit,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic              line,
  output logic              busy
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [FRAME_W-1:0] sr;
  logic [SUB_W-1:0]   sub;
  logic [3:0]         left;
  logic [WORD_W-1:0]  hold_d;
  logic               hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '1;
      sub    <= '0;
      left   <= '0;
      busy   <= 1'b0;
      hold_d <= '0;
      hold_v <= 1'b0;
    end else begin
      if (tick) begin
        if (!busy) begin
          if (hold_v) begin
            sr     <= build_frame(hold_d, nine_bit);
            left   <= frame_len(nine_bit);
            sub    <= '0;
            busy   <= 1'b1;
            hold_v <= 1'b0;
          end
        end else if (sub == SUB_LAST) begin
          sub  <= '0;
          sr   <= {1'b1, sr[FRAME_W-1:1]};
          left <= left - 1'b1;
          if (left == 4'd1) busy <= 1'b0;
        end else begin
          sub <= sub + 1'b1;
        end
      end
      // A write after the launch decision keeps the new word pending.
      if (wr) begin
        hold_d <= wdata;
        hold_v <= 1'b1;
      end
    end
  end

  assign line = busy ? sr[0] : 1'b1;
endmodule

// File: rtl/uart_lc_rx.sv
module uart_lc_rx
  import uart_lc_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine_bit,
  input  logic              line_async,
  output logic              line,
  output logic              start_ok,
  output logic [WORD_W-1:0] data,
  output logic              valid,
  output logic              ferr
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

  logic [SYNC_LEN-1:0] sync;
  rx_state_e           st;
  logic [SUB_W-1:0]    sub;
  logic [3:0]          bitn;
  logic [WORD_W-1:0]   sr;
  logic                nine_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC_LEN-2:0], line_async};
  end
  assign line = sync[SYNC_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      sub      <= '0;
      bitn     <= '0;
      sr       <= '0;
      nine_q   <= 1'b0;
      data     <= '0;
      valid    <= 1'b0;
      ferr     <= 1'b0;
      start_ok <= 1'b0;
    end else begin
      valid    <= 1'b0;
      start_ok <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: if (!line) begin
            st  <= RX_START;
            sub <= '0;
          end
          RX_START: begin
            if (sub == SUB_MID) begin
              sub <= '0;
              if (!line) begin
                st       <= RX_DATA;
                bitn     <= '0;
                nine_q   <= nine_bit;
                start_ok <= 1'b1;
              end else begin
                st <= RX_IDLE;
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_DATA: begin
            if (sub == SUB_LAST) begin
              sub  <= '0;
              sr   <= {line, sr[WORD_W-1:1]};
              bitn <= bitn + 1'b1;
              if (bitn == (nine_q ? 4'd8 : 4'd7)) st <= RX_STOP;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_STOP: begin
            if (sub == SUB_LAST) begin
              sub   <= '0;
              data  <= align_word(sr, nine_q);
              valid <= 1'b1;
              ferr  <= ~line;
              st    <= line ? RX_IDLE : RX_WAIT_HIGH;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_WAIT_HIGH: if (line) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_loop_core.sv
module uart_loop_core
  import uart_lc_pkg::*;
#(
  parameter int DIV_W = 13,
  parameter int OVS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              nine_bit,
  input  logic              loop_en,
  input  logic              rx_src,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_wr,
  input  logic              rxd_in,
  input  logic              txd_pin_in,
  output logic              txd_out,
  output logic              txd_oe,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err
);
  route_e route;
  logic   baud_tick;
  logic   tx_raw;
  logic   tx_busy;
  logic   rx_sel;
  logic   rx_line;
  logic   rx_start_ok;

  assign route = pick_route(loop_en, rx_src);

  uart_lc_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (baud_div),
    .tick (baud_tick)
  );

  uart_lc_tx #(.OVS(OVS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .nine_bit(nine_bit),
    .wr      (tx_wr),
    .wdata   (tx_data),
    .line    (tx_raw),
    .busy    (tx_busy)
  );

  assign txd_out = tx_raw;
  assign txd_oe  = (route == ROUTE_SINGLE) ? tx_busy : 1'b1;

  always_comb begin
    unique case (route)
      ROUTE_LOOP:   rx_sel = tx_raw;
      ROUTE_SINGLE: rx_sel = txd_oe ? tx_raw : txd_pin_in;
      default:      rx_sel = rxd_in;
    endcase
  end

  uart_lc_rx #(.OVS(OVS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .nine_bit  (nine_bit),
    .line_async(rx_sel),
    .line      (rx_line),
    .start_ok  (rx_start_ok),
    .data      (rx_data),
    .valid     (rx_valid),
    .ferr      (rx_frame_err)
  );
endmodule

// File: rtl/uart_lc_core_chk.sv
module uart_lc_core_chk #(
  parameter int DIV_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] baud_div,
  input logic             baud_tick,
  input logic             tx_busy,
  input logic             txd_out,
  input logic             txd_oe,
  input logic             loop_en,
  input logic             rx_src,
  input logic             rx_valid,
  input logic             rx_start_ok,
  input logic             rx_line
);
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd_out);

  a_r2_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_div == '0 && $past(baud_div) == '0) |-> !baud_tick);

  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && baud_div > 1) |=> (!baud_tick || !$stable(baud_div)));

  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd_out);

  a_r8_oe_outside_single: assert property (@(posedge clk) disable iff (!rst_n)
    !(loop_en && rx_src) |-> txd_oe);

  a_r7_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && rx_src && !tx_busy) |-> !txd_oe);

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r12_start_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start_ok |-> !$past(rx_line));
endmodule

bind uart_loop_core uart_lc_core_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_div   (baud_div),
  .baud_tick  (baud_tick),
  .tx_busy    (tx_busy),
  .txd_out    (txd_out),
  .txd_oe     (txd_oe),
  .loop_en    (loop_en),
  .rx_src     (rx_src),
  .rx_valid   (rx_valid),
  .rx_start_ok(rx_start_ok),
  .rx_line    (rx_line)
);

// File: tb/uart_loop_core_test.sv
module uart_loop_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] baud_div = 13'd2;
  logic        nine_bit = 1'b0;
  logic        loop_en = 1'b0;
  logic        rx_src = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        tx_wr = 1'b0;
  logic        rxd_in = 1'b1;
  logic        ext_line = 1'b1;
  logic        txd_pin_in;
  logic        txd_out, txd_oe, rx_valid, rx_frame_err;
  logic [8:0]  rx_data;

  int n_chk = 0;
  int n_fail = 0;
  int D = 2;
  int got_n = 0;
  logic [8:0] got_d = '0;
  logic got_e = 1'b0;

  always #2.5 clk = ~clk;

  assign txd_pin_in = txd_oe ? txd_out : ext_line;

  uart_loop_core uut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .nine_bit(nine_bit),
    .loop_en(loop_en), .rx_src(rx_src), .tx_data(tx_data), .tx_wr(tx_wr),
    .rxd_in(rxd_in), .txd_pin_in(txd_pin_in), .txd_out(txd_out), .txd_oe(txd_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      got_n = got_n + 1;
      got_d = rx_data;
      got_e = rx_frame_err;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_div(input int d);
    @(negedge clk);
    D = d;
    baud_div = 13'(d);
  endtask

  task automatic write_tx(input logic [8:0] w);
    @(negedge clk);
    tx_data = w;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic bits(input int n);
    repeat (n * 16 * D) @(negedge clk);
  endtask

  task automatic wait_fall(input int limit, output bit seen, output int waited);
    seen = 1'b0;
    waited = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      waited++;
      if (!txd_out) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  // Samples each bit at its centre; returns after sampling the stop bit.
  task automatic capture(input bit nine, input int limit, output bit seen,
                         output logic [8:0] w, output bit start_lo, output bit stop_hi,
                         output int waited);
    w = '0;
    start_lo = 1'b0;
    stop_hi = 1'b0;
    wait_fall(limit, seen, waited);
    if (seen) begin
      repeat (8 * D) @(negedge clk);
      start_lo = !txd_out;
      for (int i = 0; i < (nine ? 9 : 8); i++) begin
        repeat (16 * D) @(negedge clk);
        w[i] = txd_out;
      end
      repeat (16 * D) @(negedge clk);
      stop_hi = txd_out;
    end
  endtask

  task automatic drive_frame(input logic [8:0] w, input bit nine, input bit stop);
    @(negedge clk);
    rxd_in = 1'b0;
    bits(1);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxd_in = w[i];
      bits(1);
    end
    rxd_in = stop;
    bits(1);
    rxd_in = 1'b1;
    bits(1);
  endtask

  task automatic drive_ext(input logic [7:0] w);
    @(negedge clk);
    ext_line = 1'b0;
    bits(1);
    for (int i = 0; i < 8; i++) begin
      ext_line = w[i];
      bits(1);
    end
    ext_line = 1'b1;
    bits(2);
  endtask

  task automatic t_reset;
    chk(txd_out === 1'b1, "R10 idle txd", int'(txd_out), 1);
    chk(txd_oe === 1'b1, "R10 oe after reset", int'(txd_oe), 1);
    chk(rx_valid === 1'b0, "R10 rx_valid after reset", int'(rx_valid), 0);
  endtask

  task automatic t_bit_period(input int d);
    bit seen;
    int waited, low;
    set_div(d);
    write_tx(9'h001);
    wait_fall(4 * d + 8, seen, waited);
    low = 1;
    while (!txd_out && low < 100 * d) begin
      @(negedge clk);
      if (!txd_out) low++;
    end
    chk(seen && low == 16 * d, "R1 start bit length", low, 16 * d);
    bits(10);
  endtask

  task automatic t_frame8;
    bit seen, slo, shi;
    int waited;
    logic [8:0] w;
    set_div(2);
    write_tx(9'h0A5);
    capture(1'b0, 16, seen, w, slo, shi, waited);
    chk(seen && slo, "R3 start bit low", int'(slo), 1);
    chk(w[7:0] == 8'hA5, "R3 data lsb first", int'(w[7:0]), 'hA5);
    chk(shi, "R3 stop bit high", int'(shi), 1);
    bits(2);
    chk(txd_out === 1'b1, "R10 idle after frame", int'(txd_out), 1);
  endtask

  task automatic t_frame9;
    bit seen, slo, shi;
    int waited;
    logic [8:0] w;
    nine_bit = 1'b1;
    write_tx(9'h1C3);
    capture(1'b1, 16, seen, w, slo, shi, waited);
    chk(seen && w == 9'h1C3, "R4 nine-bit frame", int'(w), 'h1C3);
    chk(shi, "R4 stop after ninth bit", int'(shi), 1);
    bits(2);
    nine_bit = 1'b0;
  endtask

  task automatic t_rx_normal;
    int n0;
    n0 = got_n;
    drive_frame(9'h03C, 1'b0, 1'b1);
    chk(got_n == n0 + 1, "R5 one word received", got_n - n0, 1);
    chk(got_d == 9'h03C && !got_e, "R5 received 8-bit word", int'(got_d), 'h3C);
    nine_bit = 1'b1;
    drive_frame(9'h15A, 1'b1, 1'b1);
    chk(got_d == 9'h15A, "R4 received 9-bit word", int'(got_d), 'h15A);
    nine_bit = 1'b0;
  endtask

  task automatic t_ferr;
    int n0;
    n0 = got_n;
    drive_frame(9'h081, 1'b0, 1'b0);
    chk(got_n == n0 + 1 && got_e, "R9 framing error flagged", int'(got_e), 1);
    chk(got_d == 9'h081, "R9 word presented on error", int'(got_d), 'h81);
    chk(rx_frame_err === 1'b1, "R9 flag held", int'(rx_frame_err), 1);
    drive_frame(9'h042, 1'b0, 1'b1);
    chk(got_n == n0 + 2 && !got_e && got_d == 9'h042, "R9 next good word clears",
        int'(got_d), 'h42);
  endtask

  task automatic t_glitch;
    int n0;
    n0 = got_n;
    @(negedge clk);
    rxd_in = 1'b0;
    repeat (4 * D) @(negedge clk);
    rxd_in = 1'b1;
    bits(12);
    chk(got_n == n0, "R12 short low pulse rejected", got_n - n0, 0);
  endtask

  task automatic t_loop;
    int n0;
    n0 = got_n;
    @(negedge clk);
    loop_en = 1'b1;
    rx_src = 1'b0;
    rxd_in = 1'b0;
    write_tx(9'h05A);
    bits(12);
    chk(got_n == n0 + 1 && got_d == 9'h05A, "R6 loopback word", int'(got_d), 'h5A);
    chk(got_e == 1'b0, "R6 rxd_in ignored", int'(got_e), 0);
    rxd_in = 1'b1;
    bits(1);
    loop_en = 1'b0;
    bits(1);
  endtask

  task automatic t_rsrc_ignored;
    int n0;
    n0 = got_n;
    @(negedge clk);
    loop_en = 1'b0;
    rx_src = 1'b1;
    write_tx(9'h077);
    bits(12);
    chk(got_n == n0, "R8 tx not looped with rx_src alone", got_n - n0, 0);
    chk(txd_oe === 1'b1, "R8 oe stays high", int'(txd_oe), 1);
    drive_frame(9'h0C6, 1'b0, 1'b1);
    chk(got_n == n0 + 1 && got_d == 9'h0C6, "R8 rxd_in still used", int'(got_d), 'hC6);
    rx_src = 1'b0;
  endtask

  task automatic t_single;
    bit seen;
    int waited, n0;
    n0 = got_n;
    @(negedge clk);
    loop_en = 1'b1;
    rx_src = 1'b1;
    rxd_in = 1'b0;
    @(negedge clk);
    chk(txd_oe === 1'b0, "R7 released when idle", int'(txd_oe), 0);
    write_tx(9'h096);
    wait_fall(16, seen, waited);
    repeat (8 * D) @(negedge clk);
    chk(seen && txd_oe === 1'b1, "R7 driven during frame", int'(txd_oe), 1);
    repeat (16 * D * 10) @(negedge clk);
    chk(txd_oe === 1'b0, "R7 released after frame", int'(txd_oe), 0);
    chk(got_n == n0 + 1 && got_d == 9'h096, "R7 own frame received", int'(got_d), 'h96);
    drive_ext(8'h24);
    chk(got_n == n0 + 2 && got_d == 9'h024, "R7 external frame received", int'(got_d), 'h24);
    rxd_in = 1'b1;
    loop_en = 1'b0;
    rx_src = 1'b0;
    bits(1);
  endtask

  task automatic t_div_zero;
    bit seen, slo, shi;
    int waited, highs;
    logic [8:0] w;
    set_div(0);
    write_tx(9'h011);
    highs = 0;
    for (int i = 0; i < 640; i++) begin
      @(negedge clk);
      if (txd_out) highs++;
    end
    chk(highs == 640, "R2 no output while stopped", highs, 640);
    set_div(2);
    capture(1'b0, 16, seen, w, slo, shi, waited);
    chk(seen && w[7:0] == 8'h11, "R2 held word sent after restart", int'(w), 'h11);
    bits(2);
  endtask

  task automatic t_back_to_back;
    bit seen, slo, shi;
    int waited;
    logic [8:0] w;
    write_tx(9'h00F);
    fork
      capture(1'b0, 16, seen, w, slo, shi, waited);
      begin
        bits(3);
        write_tx(9'h0F0);
      end
    join
    chk(seen && w[7:0] == 8'h0F && shi, "R11 first frame intact", int'(w), 'h0F);
    capture(1'b0, 12 * D + 4, seen, w, slo, shi, waited);
    chk(seen && waited >= 8 * D + 1 && waited <= 10 * D + 2, "R11 next start timing",
        waited, 9 * D);
    chk(w[7:0] == 8'hF0, "R11 held word sent", int'(w), 'hF0);
    bits(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bit_period(2);
    t_bit_period(3);
    t_frame8();
    t_frame9();
    t_rx_normal();
    t_ferr();
    t_glitch();
    t_loop();
    t_rsrc_ignored();
    t_single();
    t_div_zero();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule